// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark and Replay

This block is a first-in first-out buffer whose write side and read side run on two independent clocks. Words sit in an inferred dual-port memory. Each port has an enable and a chip select, and both must be high for a request to count. Write and read positions cross between the clock domains as Gray code through synchronizer chains. The full and half-full flags are produced on the write side. The empty (or output-ready) flag is produced on the read side.

The buffer can run in one of two output styles, chosen while master reset is held. In standard style, a read request returns the word one read clock later, and the status pins mean empty and full. In fall-through style, the oldest stored word is presented on the output without any request, and the status pins mean output-ready and input-ready.

A mark input records the position of the next word the reader will receive. While mark stays high, a retransmit pulse rewinds reading to that position, so the words from there on are delivered again. The marked words count as occupied on the write side until mark is released. Master reset empties the buffer and re-samples the output style. Partial reset empties the buffer and keeps the style.

Top module: `rtx_fifo`

## Requirements
- R1: Words come out in the order they were accepted, with unchanged values. The write and read clocks may differ.
- R2: A write is accepted on a rising write clock only when wen and wcs are both 1 and the buffer is not full. A write with wcs at 0 stores nothing.
- R3: In standard style, a read fires when ren and rcs are both 1 and rd_stat is 0. rdata shows the word after that read clock edge and otherwise holds its value.
- R4: In standard style, rd_stat is 1 exactly when no unread word is stored, and wr_stat is 1 exactly when DEPTH words are held.
- R5: In fall-through style, rd_stat=1 means the oldest unread word is already on rdata without a request. ren with rcs both 1 consumes it. wr_stat=1 means at least one free entry.
- R6: fwft_sel is sampled only while mrst is 1 (1 selects fall-through, 0 selects standard). At all other times it is ignored, including during prst.
- R7: half_full is 1 exactly when the held word count is at least DEPTH/2.
- R8: A rising edge of mark records the position of the next word to be delivered. A retransmit pulse with mark high at the previous read edge makes later reads restart from that word, and any read request in that cycle is dropped. Retransmit is ignored when mark was low at the previous read edge.
- R9: While mark is high, the entries from the marked word onward stay held: they count toward wr_stat and half_full, and writes stop once DEPTH of them are held.
- R10: After mrst or prst, the buffer is empty, the mark is cleared, rdata is 0 and half_full is 0. rd_stat and wr_stat show the empty state of the selected style (standard: rd_stat 1, wr_stat 0; fall-through: rd_stat 0, wr_stat 1).
- R11: Reads while nothing is available and writes while full are ignored and move no position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high, keeps style |
| fwft_sel | input | 1 | Output style, sampled during master reset |
| wen | input | 1 | Write enable |
| wcs | input | 1 | Write chip select |
| wdata | input | DATA_W | Write data |
| wr_stat | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | Held count at least half the depth |
| ren | input | 1 | Read enable |
| rcs | input | 1 | Read chip select, sampled on rclk |
| mark | input | 1 | Level: rising edge records the read position, high keeps it |
| rtx | input | 1 | Retransmit pulse |
| rdata | output | DATA_W | Read data |
| rd_stat | output | 1 | Empty (standard) or output-ready (fall-through) |

## Verification
The assertions take for granted that each reset is held for several edges of both clocks, with no write or read request while it is held. They also assume that mark stays high through a retransmit, and that inputs change away from the sampling edge of their domain. The bench drives both domains from one clock and changes every input on the falling edge. It holds each reset for three cycles with all requests low and raises retransmit only while mark is already high, except in the one step that checks that a retransmit without a mark is ignored. Flag values are compared exactly only after a settling gap. On every other cycle, a flag is only checked not to claim room or data that the reference queue lacks.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/rtx_fifo_sync.sv
module rtx_fifo_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rtx_fifo_ram.sv
module rtx_fifo_ram #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port doubles as the block's output register
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rtx_fifo_wside.sv
module rtx_fifo_wside
  import rtx_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mrst,
  input  logic          fwft_sel,
  input  logic          wen,
  input  logic          wcs,
  input  logic [AW:0]   tail_gray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wr_gray,
  output logic          full,
  output logic          stat,
  output logic          half
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP  = PW'(1 << AW);
  localparam logic [PW-1:0] HALF = PW'(1 << (AW - 1));

  fifo_mode_e    mode_q;
  logic [PW-1:0] wr_ptr, wr_nxt, tail_bin, lvl;
  logic          full_q, half_q, stat_q, put, full_nxt, half_nxt;

  always_comb begin
    tail_bin = PW'(gray_to_bin(32'(tail_gray_s)));
    put      = wen & wcs & ~full_q;
    wr_nxt   = wr_ptr + PW'(put);
    lvl      = wr_nxt - tail_bin;
    full_nxt = (lvl == CAP);
    half_nxt = (lvl >= HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      wr_gray <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
      if (mrst) mode_q <= fifo_mode_e'(fwft_sel);
      stat_q  <= mrst ? fwft_sel : (mode_q == MODE_FWFT);
    end else begin
      wr_ptr  <= wr_nxt;
      wr_gray <= PW'(bin_to_gray(32'(wr_nxt)));
      full_q  <= full_nxt;
      half_q  <= half_nxt;
      stat_q  <= (mode_q == MODE_FWFT) ? ~full_nxt : full_nxt;
    end
  end

  assign we    = put;
  assign waddr = wr_ptr[AW-1:0];
  assign full  = full_q;
  assign stat  = stat_q;
  assign half  = half_q;

endmodule

// File: rtl/rtx_fifo_rside.sv
module rtx_fifo_rside
  import rtx_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mrst,
  input  logic          fwft_sel,
  input  logic          ren,
  input  logic          rcs,
  input  logic          mark,
  input  logic          rtx,
  input  logic [AW:0]   wr_gray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   tail_gray,
  output logic          stat,
  output logic          fwft
);

  localparam int PW = AW + 1;

  fifo_mode_e    mode_q;
  logic [PW-1:0] rd_ptr, mark_ptr, tail_q;
  logic [PW-1:0] wr_bin, rd_nxt, pos_cur, pos_nxt, mark_ptr_nxt, target, tail_nxt;
  logic          mark_q, or_q, mt_q, stat_q;
  logic          fw, rtx_hit, ask, consume, fetch, or_nxt, mt_nxt;

  always_comb begin
    fw       = (mode_q == MODE_FWFT);
    wr_bin   = PW'(gray_to_bin(32'(wr_gray_s)));
    rtx_hit  = rtx & mark_q;
    ask      = ren & rcs & ~rtx_hit;
    consume  = fw & ask & or_q;
    fetch    = ~rtx_hit & ~mt_q & (fw ? (~or_q | consume) : ask);
    rd_nxt   = rtx_hit ? mark_ptr : rd_ptr + PW'(fetch);
    or_nxt   = fw & ~rtx_hit & (fetch | (or_q & ~consume));
    mt_nxt   = (rd_nxt == wr_bin);
    // position of the next word the reader will receive
    pos_cur  = rd_ptr - PW'(or_q);
    pos_nxt  = rd_nxt - PW'(or_nxt);
    mark_ptr_nxt = (mark & ~mark_q) ? pos_cur : mark_ptr;
    // the released point walks one entry per cycle so its Gray code
    // never changes more than one bit
    target   = mark ? mark_ptr_nxt : pos_nxt;
    tail_nxt = tail_q + PW'(tail_q != target);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      mark_ptr  <= '0;
      tail_q    <= '0;
      tail_gray <= '0;
      mark_q    <= 1'b0;
      or_q      <= 1'b0;
      mt_q      <= 1'b1;
      if (mrst) mode_q <= fifo_mode_e'(fwft_sel);
      stat_q    <= mrst ? ~fwft_sel : ~fw;
    end else begin
      rd_ptr    <= rd_nxt;
      mark_ptr  <= mark_ptr_nxt;
      tail_q    <= tail_nxt;
      tail_gray <= PW'(bin_to_gray(32'(tail_nxt)));
      mark_q    <= mark;
      or_q      <= or_nxt;
      mt_q      <= mt_nxt;
      stat_q    <= fw ? or_nxt : mt_nxt;
    end
  end

  assign re    = fetch;
  assign raddr = rd_ptr[AW-1:0];
  assign stat  = stat_q;
  assign fwft  = fw;

endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              fwft_sel,
  input  logic              wen,
  input  logic              wcs,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_stat,
  output logic              half_full,
  input  logic              ren,
  input  logic              rcs,
  input  logic              mark,
  input  logic              rtx,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_stat
);

  localparam int PW = ADDR_W + 1;

  logic              rst_any;
  logic              w_we, w_full, r_re, r_fwft;
  logic [ADDR_W-1:0] w_addr, r_addr;
  logic [PW-1:0]     wr_gray, wr_gray_s, tail_gray, tail_gray_s;

  assign rst_any = mrst | prst;

  rtx_fifo_wside #(.AW(ADDR_W)) u_wside (
    .clk(wclk), .rst(rst_any), .mrst(mrst), .fwft_sel(fwft_sel),
    .wen(wen), .wcs(wcs), .tail_gray_s(tail_gray_s),
    .we(w_we), .waddr(w_addr), .wr_gray(wr_gray),
    .full(w_full), .stat(wr_stat), .half(half_full)
  );

  rtx_fifo_rside #(.AW(ADDR_W)) u_rside (
    .clk(rclk), .rst(rst_any), .mrst(mrst), .fwft_sel(fwft_sel),
    .ren(ren), .rcs(rcs), .mark(mark), .rtx(rtx), .wr_gray_s(wr_gray_s),
    .re(r_re), .raddr(r_addr), .tail_gray(tail_gray),
    .stat(rd_stat), .fwft(r_fwft)
  );

  rtx_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rst_any), .d(wr_gray), .q(wr_gray_s)
  );

  rtx_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(rst_any), .d(tail_gray), .q(tail_gray_s)
  );

  rtx_fifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wclk), .we(w_we), .waddr(w_addr), .wdata(wdata),
    .rclk(rclk), .rrst(rst_any), .re(r_re), .raddr(r_addr), .rdata(rdata)
  );

endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          prst,
  input logic          wen,
  input logic          wcs,
  input logic          ren,
  input logic          rcs,
  input logic          rtx,
  input logic          rd_stat,
  input logic          half_full,
  input logic          w_full,
  input logic          r_fwft,
  input logic [AW:0]   wr_gray,
  input logic [AW:0]   tail_gray,
  input logic [DW-1:0] rdata
);

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (mrst || prst)
    (w_full && wen && wcs) |=> $stable(wr_gray)); // R11

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (mrst || prst)
    (!r_fwft && rd_stat && ren && rcs) |=> $stable(rdata)); // R3

  AST_WR_GRAY_STEP: assert property (@(posedge wclk) disable iff (mrst || prst)
    ($countones(wr_gray ^ $past(wr_gray)) <= 1)); // R1

  AST_TAIL_GRAY_STEP: assert property (@(posedge rclk) disable iff (mrst || prst)
    ($countones(tail_gray ^ $past(tail_gray)) <= 1)); // R9

  AST_HEAD_HOLD: assert property (@(posedge rclk) disable iff (mrst || prst)
    (r_fwft && rd_stat && !(ren && rcs) && !rtx) |=> (rd_stat && $stable(rdata))); // R5

  AST_FULL_HAS_HALF: assert property (@(posedge wclk) disable iff (mrst || prst)
    w_full |-> half_full); // R7

endmodule

bind rtx_fifo rtx_fifo_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
  .wen(wen), .wcs(wcs), .ren(ren), .rcs(rcs), .rtx(rtx),
  .rd_stat(rd_stat), .half_full(half_full), .w_full(w_full), .r_fwft(r_fwft),
  .wr_gray(wr_gray), .tail_gray(tail_gray), .rdata(rdata)
);

// File: tb/rtx_fifo_tb.sv
module rtx_fifo_tb;

  localparam int DW = 18;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0;
  logic wen = 1'b0, wcs = 1'b0, ren = 1'b0, rcs = 1'b0, mark = 1'b0, rtx = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic wr_stat, half_full, rd_stat;

  rtx_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .wen(wen), .wcs(wcs), .wdata(wdata), .wr_stat(wr_stat), .half_full(half_full),
    .ren(ren), .rcs(rcs), .mark(mark), .rtx(rtx), .rdata(rdata), .rd_stat(rd_stat)
  );

  int n_tests = 0, n_fail = 0;
  int mwr = 0, mrd = 0, mmark = 0;
  bit mprev = 0, fw = 0;
  logic [DW-1:0] hist [int];
  logic [DW-1:0] exp_q = '0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int prot();
    return mprev ? mmark : mrd;
  endfunction

  // one clock of stimulus plus reference-model update and output compare
  task automatic step();
    bit full_obs, wfire, rfire, hit;
    full_obs = fw ? !wr_stat : wr_stat;
    if (!full_obs) chk("R9", "room claimed by write side", (DEPTH - (mwr - prot())) > 0, 1);
    if (!fw && !rd_stat) chk("R11", "data claimed by read side", mrd < mwr, 1);
    hit   = rtx && mprev;
    wfire = wen && wcs && !full_obs;
    rfire = ren && rcs && !hit && (fw ? rd_stat : !rd_stat);
    if (mark && !mprev) mmark = mrd;
    if (wfire) begin hist[mwr] = wdata; mwr++; end
    if (rfire && mrd < mwr) begin
      if (!fw) exp_q = hist[mrd];
      mrd++;
    end
    if (hit) mrd = mmark;
    mprev = mark;
    @(posedge clk);
    @(negedge clk);
    if (!fw) chk("R3", "rdata", rdata, exp_q);
    else if (rd_stat) begin
      chk("R5", "head word present", mrd < mwr, 1);
      if (mrd < mwr) chk("R1", "head word value", rdata, hist[mrd]);
    end
  endtask

  task automatic cyc(input bit w, input logic [DW-1:0] d, input bit wc,
                     input bit r, input bit rc, input bit rt);
    wen = w; wdata = d; wcs = wc; ren = r; rcs = rc; rtx = rt;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, 0);
  endtask

  task automatic settle(input string req);
    int held, pend;
    idle(24);
    held = mwr - prot();
    pend = mwr - mrd;
    if (!fw) begin
      chk(req, "empty flag", rd_stat, pend == 0);
      chk(req, "full flag", wr_stat, held == DEPTH);
    end else begin
      chk(req, "output-ready", rd_stat, pend > 0);
      chk(req, "input-ready", wr_stat, held < DEPTH);
    end
    chk("R7", "half_full", half_full, held >= DEPTH / 2);
  endtask

  task automatic do_reset(input bit master, input bit sel);
    wen = 0; wcs = 0; ren = 0; rcs = 0; rtx = 0; mark = 0;
    mrst = master; prst = !master; fwft_sel = sel;
    repeat (3) @(negedge clk);
    mrst = 0; prst = 0; fwft_sel = !sel;   // R6: flipped value must be ignored
    mwr = 0; mrd = 0; mmark = 0; mprev = 0; exp_q = '0;
    hist.delete();
    if (master) fw = sel;
    @(negedge clk);
    chk("R10", "rdata after reset", rdata, 0);
    chk("R10", "rd_stat after reset", rd_stat, fw ? 0 : 1);
    chk("R10", "wr_stat after reset", wr_stat, fw ? 1 : 0);
    chk("R10", "half_full after reset", half_full, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R6, R10: standard style chosen at master reset
    do_reset(1, 0);

    // R2: writes with wcs low store nothing
    for (int i = 0; i < 6; i++) cyc(1, DW'('h1000 + i), (i % 3) != 1, 0, 0, 0);
    settle("R4");
    // R3, R11: reads gated by rcs, extra reads on empty ignored
    for (int i = 0; i < 12; i++) cyc(0, '0, 0, 1, i % 2, 0);
    settle("R4");

    // R4, R11: fill past capacity
    for (int i = 0; i < 20; i++) cyc(1, DW'('h2000 + i), 1, 0, 0, 0);
    settle("R4");
    chk("R4", "full after overfill", wr_stat, 1);

    // R1: concurrent traffic
    for (int i = 0; i < 40; i++) cyc(i % 3 != 0, DW'('h3000 + i), 1, i % 2 == 0, 1, 0);
    for (int i = 0; i < 30; i++) cyc(0, '0, 0, 1, 1, 0);
    settle("R1");

    // R8: mark, read on, retransmit, replay
    for (int i = 0; i < 10; i++) cyc(1, DW'('h4000 + i), 1, 0, 0, 0);
    settle("R4");
    for (int i = 0; i < 2; i++) cyc(0, '0, 0, 1, 1, 0);
    mark = 1;
    for (int i = 0; i < 3; i++) cyc(0, '0, 0, 1, 1, 0);
    cyc(0, '0, 0, 1, 1, 1);
    cyc(0, '0, 0, 1, 1, 0);
    chk("R8", "first replayed word", rdata, 'h4002);
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, 1, 1, 0);
    // R9: marked entries stay held, writes stop at capacity
    for (int i = 0; i < 20; i++) cyc(1, DW'('h5000 + i), 1, 0, 0, 0);
    settle("R9");
    chk("R9", "full counted from mark", wr_stat, 1);
    mark = 0;
    settle("R9");
    for (int i = 0; i < 24; i++) cyc(0, '0, 0, 1, 1, 0);
    settle("R4");

    // R8: retransmit without a mark is ignored
    for (int i = 0; i < 3; i++) cyc(1, DW'('h6000 + i), 1, 0, 0, 0);
    settle("R4");
    cyc(0, '0, 0, 1, 1, 0);
    cyc(0, '0, 0, 0, 0, 1);
    cyc(0, '0, 0, 1, 1, 0);
    chk("R8", "no rewind without mark", rdata, 'h6001);

    // R6, R10: partial reset keeps standard style
    do_reset(0, 1);
    chk("R6", "style kept over prst", rd_stat, 1);

    // R5, R6: fall-through style
    do_reset(1, 1);
    cyc(1, DW'('h7000), 1, 0, 0, 0);
    settle("R5");
    chk("R5", "first word without request", rdata, 'h7000);
    for (int i = 0; i < 40; i++) cyc(i % 4 != 3, DW'('h7100 + i), 1, i % 3 != 0, 1, 0);
    settle("R5");
    // R8 in fall-through style
    mark = 1;
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, 1, 1, 0);
    cyc(0, '0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) cyc(0, '0, 0, 1, 1, 0);
    // R9: fill against the mark
    for (int i = 0; i < 24; i++) cyc(1, DW'('h7800 + i), 1, 0, 0, 0);
    settle("R9");
    chk("R5", "input-ready low when held full", wr_stat, 0);
    mark = 0;
    for (int i = 0; i < 30; i++) cyc(0, '0, 0, 1, 1, 0);
    settle("R5");

    finish_run();
  end

endmodule